// File: doc/BRIEF.md
# DDR2 Precharge and Activate Timing Guard

This block watches the command pins that a memory controller drives towards a DDR2 device and judges every precharge and every activate against per-bank timing. It decodes each command from the chip-select, row-strobe, column-strobe and write-enable pins. It keeps, for each of eight banks, an open flag and two saturating down-counters: cycles left until a precharge is legal, and cycles left until an activate is legal. Reads and writes push the precharge counter out by their own spacing rules. A precharge with the all-banks address bit set is judged against every open bank together.

The guard does not block anything. It reports one registered result per command, in the cycle after the clock edge that sampled it. The result is an allow or violation pulse for precharge and activate, a protocol-error pulse for commands that make no sense for the bank state, and the set of banks that a legal precharge closes. Timing values are given in clock cycles and are captured while reset is asserted.

Top module: `ddr2_pre_guard`

## Requirements
- R1: A command is taken only on a rising edge with `cs_n` low. The pins (`ras_n`,`cas_n`,`we_n`) decode as activate = 0,1,1; read = 1,0,1; write = 1,0,0; precharge = 0,1,0. Any other pattern, or any pattern with `cs_n` high, changes no state and raises no output.
- R2: A legal precharge with `a10` low closes only bank `ba`, and `close_mask` shows the single bit `ba` set.
- R3: A legal precharge with `a10` high closes all banks. `close_mask` is all ones and `ba` has no effect.
- R4: After a read, a precharge of the same bank is legal no sooner than AL + BL/2 + max(RTP,2) − 2 cycles later. Earlier, it gives `pre_viol`.
- R5: After a write, a precharge of the same bank is legal no sooner than WL + BL/2 + WR cycles later. Earlier, it gives `pre_viol`.
- R6: After an activate, a precharge of that bank is legal no sooner than RAS cycles later.
- R7: After a precharge, an activate of that bank is legal (`act_ok`) no sooner than RP cycles later. Earlier, it gives `act_viol` and the bank stays closed.
- R8: When several reads and writes hit one bank, the earliest legal precharge is set by the latest-ending of their requirements. A later, shorter requirement never brings it forward.
- R9: A precharge of all banks is legal only if every open bank meets its own precharge limit. Otherwise `pre_viol` pulses, `close_mask` stays zero and every bank stays as it was. The same no-change rule holds for a single-bank violation.
- R10: An activate to an open bank, or a read or write to a closed bank, pulses `proto_err` and changes no state.
- R11: The timing inputs and `cfg_bl8` (0 = BL 4, 1 = BL 8) are captured on clock edges while `rst_n` is low. Changes after reset has been released have no effect.
- R12: Each result is a one-cycle pulse, registered on the edge that samples the command. All outputs are zero during reset and in cycles with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| a10 | input | 1 | All-banks select for precharge |
| ba | input | 3 | Bank address |
| cfg_al | input | 5 | Additive latency, cycles |
| cfg_wl | input | 5 | Write latency, cycles |
| cfg_bl8 | input | 1 | Burst length: 0 = 4, 1 = 8 |
| cfg_rtp | input | 5 | Read-to-precharge time, cycles |
| cfg_wr | input | 5 | Write recovery time, cycles |
| cfg_ras | input | 5 | Activate-to-precharge time, cycles |
| cfg_rp | input | 5 | Precharge-to-activate time, cycles |
| pre_ok | output | 1 | Precharge was legal and was applied |
| pre_viol | output | 1 | Precharge broke a timing limit |
| act_ok | output | 1 | Activate was legal and was applied |
| act_viol | output | 1 | Activate came before RP had elapsed |
| proto_err | output | 1 | Command does not fit the bank state |
| close_mask | output | 8 | Banks closed by a legal precharge |

## Verification
Every result is registered, so the result of a command sampled on edge N is read at the falling edge that follows N. The bench drives each command half a cycle before its edge and samples the result half a cycle after it. A spacing of S cycles is tested by placing the precharge or activate exactly S−1 and S command slots after the command it depends on. A violation at S−1 must leave state untouched, and the bench shows this by issuing the legal command at S right after. Values that are not visible directly, such as whether a bank is still open, are brought out by a following read (protocol error or not) in the next slot.

// File: rtl/ddr2_pg_pkg.sv
package ddr2_pg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

endpackage

// File: rtl/ddr2_pg_decode.sv
module ddr2_pg_decode
    import ddr2_pg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 a10,
    input  logic [BA_W-1:0]      ba,
    output cmd_e                 cmd,
    output logic                 all_banks,
    output logic [NUM_BANKS-1:0] tgt
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    // a10 widens the target only for a precharge
    assign all_banks = (cmd == CMD_PRE) && a10;

    always_comb begin
        tgt = '0;
        if (all_banks) begin
            tgt = '1;
        end else begin
            tgt[ba] = 1'b1;
        end
    end

endmodule

// File: rtl/ddr2_pg_cfg.sv
module ddr2_pg_cfg #(
    parameter int CFG_W = 5,
    parameter int CNT_W = CFG_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_al,
    input  logic [CFG_W-1:0] cfg_wl,
    input  logic             cfg_bl8,
    input  logic [CFG_W-1:0] cfg_rtp,
    input  logic [CFG_W-1:0] cfg_wr,
    input  logic [CFG_W-1:0] cfg_ras,
    input  logic [CFG_W-1:0] cfg_rp,
    output logic [CNT_W-1:0] rd_m1,
    output logic [CNT_W-1:0] wr_m1,
    output logic [CNT_W-1:0] ras_m1,
    output logic [CNT_W-1:0] rp_m1
);

    localparam int PAD = CNT_W - CFG_W;

    typedef struct packed {
        logic [CFG_W-1:0] al;
        logic [CFG_W-1:0] wl;
        logic             bl8;
        logic [CFG_W-1:0] rtp;
        logic [CFG_W-1:0] wr;
        logic [CFG_W-1:0] ras;
        logic [CFG_W-1:0] rp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.al  = cfg_al;
            cfg_d.wl  = cfg_wl;
            cfg_d.bl8 = cfg_bl8;
            cfg_d.rtp = cfg_rtp;
            cfg_d.wr  = cfg_wr;
            cfg_d.ras = cfg_ras;
            cfg_d.rp  = cfg_rp;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    logic [CNT_W-1:0] al_x, wl_x, rtp_x, wr_x, ras_x, rp_x, half_x, rtp_eff;

    always_comb begin
        al_x    = {{PAD{1'b0}}, cfg_q.al};
        wl_x    = {{PAD{1'b0}}, cfg_q.wl};
        rtp_x   = {{PAD{1'b0}}, cfg_q.rtp};
        wr_x    = {{PAD{1'b0}}, cfg_q.wr};
        ras_x   = {{PAD{1'b0}}, cfg_q.ras};
        rp_x    = {{PAD{1'b0}}, cfg_q.rp};
        half_x  = cfg_q.bl8 ? CNT_W'(4) : CNT_W'(2);
        rtp_eff = (rtp_x < CNT_W'(2)) ? CNT_W'(2) : rtp_x;
        // counters hold "cycles left minus one" after the loading edge
        rd_m1   = al_x + half_x + rtp_eff - CNT_W'(3);
        wr_m1   = wl_x + half_x + wr_x - CNT_W'(1);
        ras_m1  = (ras_x == '0) ? '0 : ras_x - CNT_W'(1);
        rp_m1   = (rp_x == '0) ? '0 : rp_x - CNT_W'(1);
    end

endmodule

// File: rtl/ddr2_pg_bank.sv
module ddr2_pg_bank #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             pre_go,
    input  logic [CNT_W-1:0] rw_m1,
    input  logic [CNT_W-1:0] ras_m1,
    input  logic [CNT_W-1:0] rp_m1,
    output logic             open_q,
    output logic             pre_rdy,
    output logic             act_rdy
);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] pre_cnt;
        logic [CNT_W-1:0] act_cnt;
    } bank_t;

    bank_t st_d, st_q;
    logic [CNT_W-1:0] pre_dec, act_dec;

    always_comb begin
        pre_dec = (st_q.pre_cnt == '0) ? '0 : st_q.pre_cnt - CNT_W'(1);
        act_dec = (st_q.act_cnt == '0) ? '0 : st_q.act_cnt - CNT_W'(1);
        st_d         = st_q;
        st_d.pre_cnt = pre_dec;
        st_d.act_cnt = act_dec;
        if (act_go) begin
            st_d.open    = 1'b1;
            st_d.pre_cnt = ras_m1;
        end else if (rw_go) begin
            st_d.pre_cnt = (rw_m1 > pre_dec) ? rw_m1 : pre_dec;
        end else if (pre_go) begin
            st_d.open    = 1'b0;
            st_d.pre_cnt = '0;
            st_d.act_cnt = rp_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_q  = st_q.open;
    assign pre_rdy = (st_q.pre_cnt == '0);
    assign act_rdy = (st_q.act_cnt == '0);

    p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> open_q);
    p_pre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> !open_q);
    p_act_waits_rp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (act_rdy && !open_q));
    p_pre_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |-> (pre_rdy || !open_q));
    p_rw_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |-> open_q);
    p_rw_keeps_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |=> (open_q && !pre_rdy));

endmodule

// File: rtl/ddr2_pre_guard.sv
module ddr2_pre_guard
    import ddr2_pg_pkg::*;
#(
    parameter int  NUM_BANKS = 8,
    parameter int  CFG_W     = 5,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 a10,
    input  logic [BA_W-1:0]      ba,
    input  logic [CFG_W-1:0]     cfg_al,
    input  logic [CFG_W-1:0]     cfg_wl,
    input  logic                 cfg_bl8,
    input  logic [CFG_W-1:0]     cfg_rtp,
    input  logic [CFG_W-1:0]     cfg_wr,
    input  logic [CFG_W-1:0]     cfg_ras,
    input  logic [CFG_W-1:0]     cfg_rp,
    output logic                 pre_ok,
    output logic                 pre_viol,
    output logic                 act_ok,
    output logic                 act_viol,
    output logic                 proto_err,
    output logic [NUM_BANKS-1:0] close_mask
);

    localparam int CNT_W = CFG_W + 3;

    typedef struct packed {
        logic                 pre_ok;
        logic                 pre_viol;
        logic                 act_ok;
        logic                 act_viol;
        logic                 proto_err;
        logic [NUM_BANKS-1:0] mask;
    } res_t;

    cmd_e                 cmd;
    logic                 all_banks;
    logic [NUM_BANKS-1:0] tgt;

    ddr2_pg_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .a10       (a10),
        .ba        (ba),
        .cmd       (cmd),
        .all_banks (all_banks),
        .tgt       (tgt)
    );

    logic [CNT_W-1:0] rd_m1, wr_m1, ras_m1, rp_m1;

    ddr2_pg_cfg #(.CFG_W(CFG_W), .CNT_W(CNT_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_al  (cfg_al),
        .cfg_wl  (cfg_wl),
        .cfg_bl8 (cfg_bl8),
        .cfg_rtp (cfg_rtp),
        .cfg_wr  (cfg_wr),
        .cfg_ras (cfg_ras),
        .cfg_rp  (cfg_rp),
        .rd_m1   (rd_m1),
        .wr_m1   (wr_m1),
        .ras_m1  (ras_m1),
        .rp_m1   (rp_m1)
    );

    logic [NUM_BANKS-1:0] open_vec, pre_rdy_vec, act_rdy_vec;
    logic [NUM_BANKS-1:0] act_go, rw_go, pre_go;
    logic [CNT_W-1:0]     rw_m1;

    assign rw_m1 = (cmd == CMD_RD) ? rd_m1 : wr_m1;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr2_pg_bank #(.CNT_W(CNT_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[b]),
            .rw_go   (rw_go[b]),
            .pre_go  (pre_go[b]),
            .rw_m1   (rw_m1),
            .ras_m1  (ras_m1),
            .rp_m1   (rp_m1),
            .open_q  (open_vec[b]),
            .pre_rdy (pre_rdy_vec[b]),
            .act_rdy (act_rdy_vec[b])
        );
    end

    // judgement of the sampled command against the bank state
    logic pre_legal, tgt_open, tgt_act_rdy;
    res_t res_d, res_q;

    always_comb begin
        pre_legal   = &(~tgt | ~open_vec | pre_rdy_vec);
        tgt_open    = |(tgt & open_vec);
        tgt_act_rdy = |(tgt & act_rdy_vec);
        act_go = '0;
        rw_go  = '0;
        pre_go = '0;
        res_d  = '0;
        unique case (cmd)
            CMD_PRE: begin
                if (pre_legal) begin
                    pre_go       = tgt;
                    res_d.pre_ok = 1'b1;
                    res_d.mask   = tgt;
                end else begin
                    res_d.pre_viol = 1'b1;
                end
            end
            CMD_ACT: begin
                if (tgt_open) begin
                    res_d.proto_err = 1'b1;
                end else if (tgt_act_rdy) begin
                    act_go       = tgt;
                    res_d.act_ok = 1'b1;
                end else begin
                    res_d.act_viol = 1'b1;
                end
            end
            CMD_RD, CMD_WR: begin
                if (tgt_open) begin
                    rw_go = tgt;
                end else begin
                    res_d.proto_err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign pre_ok     = res_q.pre_ok;
    assign pre_viol   = res_q.pre_viol;
    assign act_ok     = res_q.act_ok;
    assign act_viol   = res_q.act_viol;
    assign proto_err  = res_q.proto_err;
    assign close_mask = res_q.mask;

    p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pre_ok, pre_viol, act_ok, act_viol, proto_err}) <= 1);
    p_mask_needs_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (close_mask != '0) |-> pre_ok);
    p_all_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok && $past(all_banks)) |-> (close_mask == '1));
    p_single_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok && !$past(all_banks)) |-> ($countones(close_mask) == 1));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |=> (res_q == '0));

endmodule

// File: tb/test_ddr2_pre_guard.sv
module test_ddr2_pre_guard;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, ras_n, cas_n, we_n, a10;
    logic [2:0] ba;
    logic [4:0] cfg_al, cfg_wl, cfg_rtp, cfg_wr, cfg_ras, cfg_rp;
    logic       cfg_bl8;
    logic       pre_ok, pre_viol, act_ok, act_viol, proto_err;
    logic [7:0] close_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2_pre_guard i_ddr2_pre_guard (
        .clk (clk), .rst_n (rst_n),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .a10 (a10), .ba (ba),
        .cfg_al (cfg_al), .cfg_wl (cfg_wl), .cfg_bl8 (cfg_bl8),
        .cfg_rtp (cfg_rtp), .cfg_wr (cfg_wr), .cfg_ras (cfg_ras), .cfg_rp (cfg_rp),
        .pre_ok (pre_ok), .pre_viol (pre_viol), .act_ok (act_ok),
        .act_viol (act_viol), .proto_err (proto_err), .close_mask (close_mask)
    );

    // expected result word: {pre_ok, pre_viol, act_ok, act_viol, proto_err, mask}
    localparam logic [12:0] E_NONE = 13'h0;
    localparam logic [12:0] E_PVIO = {5'b01000, 8'h00};
    localparam logic [12:0] E_AOK  = {5'b00100, 8'h00};
    localparam logic [12:0] E_AVIO = {5'b00010, 8'h00};
    localparam logic [12:0] E_PERR = {5'b00001, 8'h00};

    localparam int K_ACT = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;
    localparam int K_PRE = 3;

    function automatic logic [12:0] e_pok(input logic [7:0] m);
        return {5'b10000, m};
    endfunction

    function automatic logic [12:0] observed();
        return {pre_ok, pre_viol, act_ok, act_viol, proto_err, close_mask};
    endfunction

    task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic idle_pins();
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; a10 = 1'b0; ba = '0;
    endtask

    // called at a falling edge; the result is read one falling edge later
    task automatic issue(input int kind, input int bank, input logic a10v,
                         input logic csv, input logic [12:0] exp, input string req);
        cs_n = csv;
        a10  = a10v;
        ba   = 3'(bank);
        case (kind)
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            default: {ras_n, cas_n, we_n} = 3'b010;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(req, observed(), exp);
        idle_pins();
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic bl8, input logic [4:0] rtp);
        idle_pins();
        cfg_al = 5'd1; cfg_wl = 5'd2; cfg_bl8 = bl8; cfg_rtp = rtp;
        cfg_wr = 5'd3; cfg_ras = 5'd5; cfg_rp = 5'd3;
        rst_n = 1'b0;
        nop(3);
        check("R12 reset outputs", observed(), E_NONE);
        rst_n = 1'b1;
        nop(1);
    endtask

    // configuration A: AL1 WL2 BL4 RTP3 WR3 RAS5 RP3 -> read 4, write 7
    task automatic t_read_spacing();
        issue(K_ACT, 1, 0, 0, E_AOK, "R6 activate bank1");
        nop(6);
        issue(K_RD, 1, 0, 0, E_NONE, "R4 read open bank1");
        nop(2);
        issue(K_PRE, 1, 0, 0, E_PVIO, "R4 precharge 3 after read");
        issue(K_PRE, 1, 0, 0, e_pok(8'h02), "R4 R2 precharge 4 after read");
    endtask

    task automatic t_write_spacing();
        issue(K_ACT, 3, 0, 0, E_AOK, "R5 activate bank3");
        nop(6);
        issue(K_WR, 3, 0, 0, E_NONE, "R5 write open bank3");
        nop(5);
        issue(K_PRE, 3, 0, 0, E_PVIO, "R5 precharge 6 after write");
        issue(K_PRE, 3, 0, 0, e_pok(8'h08), "R5 precharge 7 after write");
    endtask

    task automatic t_ras_rp();
        issue(K_ACT, 4, 0, 0, E_AOK, "R6 activate bank4");
        nop(3);
        issue(K_PRE, 4, 0, 0, E_PVIO, "R6 precharge 4 after activate");
        issue(K_PRE, 4, 0, 0, e_pok(8'h10), "R6 precharge 5 after activate");
        issue(K_ACT, 4, 0, 0, E_AVIO, "R7 activate 1 after precharge");
        issue(K_ACT, 4, 0, 0, E_AVIO, "R7 activate 2 after precharge");
        issue(K_ACT, 4, 0, 0, E_AOK, "R7 activate 3 after precharge");
    endtask

    task automatic t_latest_wins();
        issue(K_ACT, 5, 0, 0, E_AOK, "R8 activate bank5");
        nop(6);
        issue(K_WR, 5, 0, 0, E_NONE, "R8 write bank5");
        issue(K_RD, 5, 0, 0, E_NONE, "R8 read after write");
        nop(4);
        issue(K_PRE, 5, 0, 0, E_PVIO, "R8 precharge 6 after write");
        issue(K_PRE, 5, 0, 0, e_pok(8'h20), "R8 precharge 7 after write");
    endtask

    task automatic t_all_banks();
        // bank4 is open and long settled
        issue(K_ACT, 0, 0, 0, E_AOK, "R9 activate bank0");
        issue(K_PRE, 3, 1, 0, E_PVIO, "R9 all-bank precharge too early");
        issue(K_RD, 0, 0, 0, E_NONE, "R9 bank0 still open after violation");
        nop(3);
        issue(K_PRE, 3, 1, 0, e_pok(8'hFF), "R3 all-bank precharge");
        issue(K_RD, 4, 0, 0, E_PERR, "R3 bank4 closed by all-bank precharge");
        issue(K_ACT, 0, 0, 0, E_AVIO, "R7 activate 2 after all-bank precharge");
    endtask

    task automatic t_protocol();
        nop(3);
        issue(K_ACT, 6, 0, 0, E_AOK, "R10 activate bank6");
        issue(K_ACT, 6, 0, 0, E_PERR, "R10 activate open bank6");
        issue(K_RD, 6, 0, 0, E_NONE, "R10 bank6 open once");
        issue(K_RD, 7, 0, 0, E_PERR, "R10 read closed bank7");
        issue(K_WR, 2, 0, 0, E_PERR, "R10 write closed bank2");
    endtask

    task automatic t_chip_select();
        issue(K_ACT, 7, 0, 1, E_NONE, "R1 activate with cs_n high");
        issue(K_RD, 7, 0, 0, E_PERR, "R1 bank7 stayed closed");
        issue(K_PRE, 6, 0, 1, E_NONE, "R1 precharge with cs_n high");
        issue(K_RD, 6, 0, 0, E_NONE, "R1 bank6 stayed open");
        nop(1);
        check("R12 idle cycle quiet", observed(), E_NONE);
    endtask

    // configuration B: BL8, RTP1 -> read spacing 1+4+2-2 = 5
    task automatic t_bl8_and_capture();
        cfg_ras = 5'd1;
        cfg_rtp = 5'd9;
        cfg_bl8 = 1'b0;
        issue(K_ACT, 2, 0, 0, E_AOK, "R4 activate bank2 BL8");
        nop(6);
        issue(K_RD, 2, 0, 0, E_NONE, "R4 read bank2 BL8");
        nop(3);
        issue(K_PRE, 2, 0, 0, E_PVIO, "R4 R11 precharge 4 after BL8 read");
        issue(K_PRE, 2, 0, 0, e_pok(8'h04), "R4 R11 precharge 5 after BL8 read");
        issue(K_ACT, 1, 0, 0, E_AOK, "R11 activate bank1");
        issue(K_PRE, 1, 0, 0, E_PVIO, "R11 RAS held at reset value");
    endtask

    bit done = 0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_pins();
        rst_n = 1'b0;
        @(negedge clk);
        do_reset(1'b0, 5'd3);
        t_read_spacing();
        t_write_spacing();
        t_ras_rp();
        t_latest_wins();
        t_all_banks();
        t_protocol();
        t_chip_select();
        do_reset(1'b1, 5'd1);
        t_bl8_and_capture();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule